// File: doc/BRIEF.md
# Two-layer nibble bitmap pixel compositor

This block sits between a character-row raster timing source and a palette. For every byte slot it forms two video RAM read addresses, one per bitmap layer, from the row memory address, the raster line inside the character row and the byte index inside the row. The video RAM is outside the block. It is a synchronous memory with two read ports, and it returns each byte on the clock after its address is presented. Each fetched byte packs two horizontally adjacent 4-bit pixels.

The two layers are merged with a transparent-zero rule on the upper layer. A 3-bit colour bank is added to each result, giving one 8-bit palette index per pixel. Each pixel carries its screen x and y, and both coordinates are mirrored when the screen is flipped. When video is disabled, a pixel comes out blanked with index zero. The colour bank and the flip setting are captured only at a line-start strobe, so a change in the middle of a line takes effect on the next line.

Top module: `pixcomp_top`

## Requirements
- R1: In the same cycle as `slot_valid`, `vram_bg_addr` equals (0x0400 + ((`crtc_ma` << 3) | (`crtc_ra` << 7) | `slot_col`)), truncated to 16 bits. The memory returns `vram_bg_data` and `vram_fg_data` on the following clock.
- R2: `vram_fg_addr` always equals `vram_bg_addr` with bit 15 forced to 1, which selects the upper 32 KB half.
- R3: A slot presented in cycle t produces `pix_valid` in cycles t+2 and t+3. The pixel in cycle t+2 is taken from the low nibble (bits 3:0) at x = 2*`slot_col`. The pixel in cycle t+3 is taken from the high nibble (bits 7:4) at x = 2*`slot_col`+1.
- R4: If the foreground nibble is 0, `pix_index` = {bank[2:0], 1'b0, background nibble}.
- R5: If the foreground nibble is nonzero, `pix_index` = {bank[2:0], 1'b1, foreground nibble}, and the background nibble has no effect.
- R6: With flip captured, `pix_x` = (256 - x) mod 256 and `pix_y` = (240 - `line_no`) mod 256. Without flip, `pix_y` = `line_no` and `pix_x` = x.
- R7: A slot presented while `video_en` is 0 yields pixels with `pix_blank` = 1 and `pix_index` = 0. When `video_en` is 1, `pix_blank` = 0.
- R8: `bank_in` and `flip_in` are captured only in cycles where `line_start` = 1. Slots use the last captured values, so changing these inputs at any other time does not affect the output.
- R9: After reset, and in every cycle not named in R3, `pix_valid` = 0.
- R10: Two `slot_valid` pulses are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| slot_valid | input | 1 | a byte slot is presented this cycle |
| line_start | input | 1 | capture bank and flip for the coming line |
| crtc_ma | input | MA_W (13) | row memory address from the timing source |
| crtc_ra | input | RA_W (5) | raster line inside the character row |
| slot_col | input | COL_W (7) | byte index inside the row |
| line_no | input | 8 | screen line of this slot |
| bank_in | input | 3 | colour bank |
| flip_in | input | 1 | screen flip request |
| video_en | input | 1 | video enable, sampled with each slot |
| vram_bg_addr | output | 16 | background layer read address |
| vram_fg_addr | output | 16 | foreground layer read address |
| vram_bg_data | input | 8 | background byte, one clock after address |
| vram_fg_data | input | 8 | foreground byte, one clock after address |
| pix_valid | output | 1 | a pixel is present |
| pix_index | output | 8 | palette index |
| pix_x | output | 8 | screen x of the pixel |
| pix_y | output | 8 | screen y of the pixel |
| pix_blank | output | 1 | pixel is blanked (video disabled) |

## Verification
A stale or wrong captured bank or flip shows up on the first pixel of the next slot: its index bits 7:5, or its mirrored coordinates, differ from the expected values two cycles after that slot is presented. A broken nibble order or a broken transparency choice shows up within the same pixel pair, because the reference model predicts both pixels of every slot from the same memory function. A lost or duplicated second pixel shows as `pix_valid` in a cycle where the model expects idle, or as no `pix_valid` where it expects a pixel, and the per-clock comparison catches it within one cycle.

// File: rtl/pixcomp_pkg.sv
package pixcomp_pkg;
    localparam int VA_W         = 16;
    localparam int NIB_W        = 4;
    localparam int PIX_PER_BYTE = 8 / NIB_W;
    localparam int BANK_W       = 3;
    localparam int IDX_W        = BANK_W + 1 + NIB_W;
    localparam int COORD_W      = 8;
    localparam logic [COORD_W-1:0] FLIP_Y_REF = 8'd240;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [COORD_W-1:0] x;
    } pixel_t;

    typedef struct packed {
        logic               valid;
        logic               en;
        logic               flip;
        logic [BANK_W-1:0]  bank;
        logic [COORD_W-1:0] x0;
        logic [COORD_W-1:0] line;
    } slot_t;

    // upper layer wins unless its nibble is zero
    function automatic logic [IDX_W-1:0] layer_pick(
        input logic [BANK_W-1:0] bank,
        input logic [NIB_W-1:0]  bg_nib,
        input logic [NIB_W-1:0]  fg_nib
    );
        if (fg_nib != '0)
            return {bank, 1'b1, fg_nib};
        return {bank, 1'b0, bg_nib};
    endfunction

    function automatic logic [COORD_W-1:0] mirror_coord(
        input logic               flip,
        input logic [COORD_W-1:0] ref_pt,
        input logic [COORD_W-1:0] v
    );
        return flip ? (ref_pt - v) : v;
    endfunction
endpackage

// File: rtl/pixcomp_addr.sv
module pixcomp_addr
    import pixcomp_pkg::*;
#(
    parameter int MA_W = 13,
    parameter int RA_W = 5,
    parameter int COL_W = 7,
    parameter logic [VA_W-1:0] BASE = 16'h0400
) (
    input  logic [MA_W-1:0]  ma,
    input  logic [RA_W-1:0]  ra,
    input  logic [COL_W-1:0] col,
    output logic [VA_W-1:0]  bg_addr,
    output logic [VA_W-1:0]  fg_addr
);
    localparam int MA_SH = 3;
    localparam int RA_SH = 7;
    localparam int HALF_BIT = VA_W - 1;

    logic [VA_W-1:0] mix;

    assign mix     = (VA_W'(ma) << MA_SH) | (VA_W'(ra) << RA_SH) | VA_W'(col);
    assign bg_addr = mix + BASE;
    assign fg_addr = bg_addr | (VA_W'(1) << HALF_BIT);
endmodule

// File: rtl/pixcomp_stage.sv
module pixcomp_stage
    import pixcomp_pkg::*;
#(
    parameter int COL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [BANK_W-1:0]  bank_in,
    input  logic               flip_in,
    input  logic               slot_valid,
    input  logic               video_en,
    input  logic [COL_W-1:0]   col,
    input  logic [COORD_W-1:0] line_no,
    output slot_t              st
);
    logic [BANK_W-1:0] line_bank;
    logic              line_flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_bank <= '0;
            line_flip <= 1'b0;
            st        <= '0;
        end else begin
            if (line_start) begin
                line_bank <= bank_in;
                line_flip <= flip_in;
            end
            st.valid <= slot_valid;
            if (slot_valid) begin
                st.en   <= video_en;
                st.flip <= line_flip;
                st.bank <= line_bank;
                st.x0   <= COORD_W'({col, 1'b0});
                st.line <= line_no;
            end
        end
    end
endmodule

// File: rtl/pixcomp_merge.sv
module pixcomp_merge
    import pixcomp_pkg::*;
(
    input  slot_t                       st,
    input  logic [7:0]                  bg_byte,
    input  logic [7:0]                  fg_byte,
    output pixel_t [PIX_PER_BYTE-1:0]   px,
    output logic [COORD_W-1:0]          y,
    output logic                        blank
);
    localparam logic [COORD_W-1:0] X_REF = '0;

    for (genvar g = 0; g < PIX_PER_BYTE; g++) begin : g_nib
        logic [NIB_W-1:0] bg_n, fg_n;
        assign bg_n     = bg_byte[g*NIB_W +: NIB_W];
        assign fg_n     = fg_byte[g*NIB_W +: NIB_W];
        assign px[g].idx = st.en ? layer_pick(st.bank, bg_n, fg_n) : '0;
        assign px[g].x   = mirror_coord(st.flip, X_REF, st.x0 + COORD_W'(g));
    end

    assign y     = mirror_coord(st.flip, FLIP_Y_REF, st.line);
    assign blank = !st.en;
endmodule

// File: rtl/pixcomp_serial.sv
module pixcomp_serial
    import pixcomp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  pixel_t [PIX_PER_BYTE-1:0] px,
    input  logic [COORD_W-1:0]        y_in,
    input  logic                      blank_in,
    output logic                      pix_valid,
    output pixel_t                    pix,
    output logic [COORD_W-1:0]        pix_y,
    output logic                      pix_blank
);
    localparam int PIX_W = $bits(pixel_t);
    localparam int CNT_W = $clog2(PIX_PER_BYTE + 1);

    pixel_t [PIX_PER_BYTE-1:0] hold;
    logic [CNT_W-1:0]          left;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold      <= '0;
            left      <= '0;
            pix_valid <= 1'b0;
            pix       <= '0;
            pix_y     <= '0;
            pix_blank <= 1'b0;
        end else if (load) begin
            pix       <= px[0];
            hold      <= px >> PIX_W;
            left      <= CNT_W'(PIX_PER_BYTE - 1);
            pix_valid <= 1'b1;
            pix_y     <= y_in;
            pix_blank <= blank_in;
        end else if (left != '0) begin
            pix       <= hold[0];
            hold      <= hold >> PIX_W;
            left      <= left - 1'b1;
            pix_valid <= 1'b1;
        end else begin
            pix_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pixcomp_top.sv
module pixcomp_top
    import pixcomp_pkg::*;
#(
    parameter int MA_W = 13,
    parameter int RA_W = 5,
    parameter int COL_W = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_valid,
    input  logic               line_start,
    input  logic [MA_W-1:0]    crtc_ma,
    input  logic [RA_W-1:0]    crtc_ra,
    input  logic [COL_W-1:0]   slot_col,
    input  logic [7:0]         line_no,
    input  logic [2:0]         bank_in,
    input  logic               flip_in,
    input  logic               video_en,
    output logic [15:0]        vram_bg_addr,
    output logic [15:0]        vram_fg_addr,
    input  logic [7:0]         vram_bg_data,
    input  logic [7:0]         vram_fg_data,
    output logic               pix_valid,
    output logic [7:0]         pix_index,
    output logic [7:0]         pix_x,
    output logic [7:0]         pix_y,
    output logic               pix_blank
);
    slot_t                     st;
    pixel_t [PIX_PER_BYTE-1:0] merged;
    logic [COORD_W-1:0]        merged_y;
    logic                      merged_blank;
    pixel_t                    out_px;

    pixcomp_addr #(.MA_W(MA_W), .RA_W(RA_W), .COL_W(COL_W)) i_addr (
        .ma(crtc_ma), .ra(crtc_ra), .col(slot_col),
        .bg_addr(vram_bg_addr), .fg_addr(vram_fg_addr)
    );

    pixcomp_stage #(.COL_W(COL_W)) i_stage (
        .clk(clk), .rst(rst), .line_start(line_start),
        .bank_in(bank_in), .flip_in(flip_in), .slot_valid(slot_valid),
        .video_en(video_en), .col(slot_col), .line_no(line_no), .st(st)
    );

    pixcomp_merge i_merge (
        .st(st), .bg_byte(vram_bg_data), .fg_byte(vram_fg_data),
        .px(merged), .y(merged_y), .blank(merged_blank)
    );

    pixcomp_serial i_serial (
        .clk(clk), .rst(rst), .load(st.valid), .px(merged),
        .y_in(merged_y), .blank_in(merged_blank),
        .pix_valid(pix_valid), .pix(out_px), .pix_y(pix_y), .pix_blank(pix_blank)
    );

    assign pix_index = out_px.idx;
    assign pix_x     = out_px.x;
endmodule

// File: rtl/pixcomp_chk.sv
module pixcomp_chk
    import pixcomp_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            slot_valid,
    input logic [VA_W-1:0] bg_addr,
    input logic [VA_W-1:0] fg_addr,
    input logic            pix_valid,
    input logic [7:0]      pix_index,
    input logic            pix_blank
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else     age <= {age[1:0], slot_valid};
    end

    assert_fg_half_R2: assert property (@(posedge clk) disable iff (rst)
        fg_addr[VA_W-1] && (fg_addr[VA_W-2:0] == bg_addr[VA_W-2:0]));

    assert_first_pixel_R3: assert property (@(posedge clk) disable iff (rst)
        age[1] |-> pix_valid);

    assert_second_pixel_R3: assert property (@(posedge clk) disable iff (rst)
        age[2] |-> pix_valid);

    assert_blank_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && pix_blank) |-> (pix_index == '0));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !(age[1] || age[2]) |-> !pix_valid);

    assert_slot_spacing_R10: assert property (@(posedge clk) disable iff (rst)
        slot_valid |=> !slot_valid);
endmodule

bind pixcomp_top pixcomp_chk i_chk (
    .clk(clk), .rst(rst), .slot_valid(slot_valid),
    .bg_addr(vram_bg_addr), .fg_addr(vram_fg_addr),
    .pix_valid(pix_valid), .pix_index(pix_index), .pix_blank(pix_blank)
);

// File: tb/test_pixcomp_top.sv
module test_pixcomp_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, slot_valid, line_start, flip_in, video_en;
    logic [12:0] crtc_ma;
    logic [4:0]  crtc_ra;
    logic [6:0]  slot_col;
    logic [7:0]  line_no;
    logic [2:0]  bank_in;
    logic [15:0] vram_bg_addr, vram_fg_addr;
    logic [7:0]  vram_bg_data, vram_fg_data;
    logic        pix_valid, pix_blank;
    logic [7:0]  pix_index, pix_x, pix_y;

    pixcomp_top i_pixcomp_top (
        .clk(clk), .rst(rst), .slot_valid(slot_valid), .line_start(line_start),
        .crtc_ma(crtc_ma), .crtc_ra(crtc_ra), .slot_col(slot_col), .line_no(line_no),
        .bank_in(bank_in), .flip_in(flip_in), .video_en(video_en),
        .vram_bg_addr(vram_bg_addr), .vram_fg_addr(vram_fg_addr),
        .vram_bg_data(vram_bg_data), .vram_fg_data(vram_fg_data),
        .pix_valid(pix_valid), .pix_index(pix_index), .pix_x(pix_x),
        .pix_y(pix_y), .pix_blank(pix_blank)
    );

    int checks = 0, failures = 0, cyc = 0, mode = 0;
    bit done = 0;
    logic [2:0] m_bank = '0;
    bit         m_flip = 0;

    typedef struct {
        int    due;
        int    idx;
        int    x;
        int    y;
        bit    blank;
        string tag;
    } exp_t;
    exp_t q[$];

    // video RAM contents as a function of address; mode shapes the upper layer
    function automatic logic [7:0] memf(input logic [15:0] a, input bit is_fg);
        logic [7:0] h;
        h = (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5a;
        if (!is_fg) return h;
        case (mode)
            1:       return 8'h00;
            2:       return h | 8'h11;
            3:       return h & 8'hf0;
            default: return h;
        endcase
    endfunction

    always @(posedge clk) begin
        vram_bg_data <= memf(vram_bg_addr, 1'b0);
        vram_fg_data <= memf(vram_fg_addr, 1'b1);
        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                int act, expv;
                e    = q.pop_front();
                act  = {pix_valid, pix_blank, pix_y, pix_x, pix_index};
                expv = {1'b1, e.blank, e.y[7:0], e.x[7:0], e.idx[7:0]};
                check(act == expv, e.tag, "pixel{v,blank,y,x,idx}", act, expv);
            end else begin
                check(!pix_valid, "R9", "idle pix_valid", int'(pix_valid), 0);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic new_line(input logic [2:0] bank, input bit flip);
        @(negedge clk);
        line_start = 1'b1;
        bank_in    = bank;
        flip_in    = flip;
        @(negedge clk);
        line_start = 1'b0;
        m_bank     = bank;
        m_flip     = flip;
    endtask

    task automatic slot(input logic [12:0] ma, input logic [4:0] ra, input logic [6:0] col,
                        input logic [7:0] line, input bit en, input string tag);
        int ea;
        logic [7:0] bgb, fgb;
        @(negedge clk);
        crtc_ma    = ma;
        crtc_ra    = ra;
        slot_col   = col;
        line_no    = line;
        video_en   = en;
        slot_valid = 1'b1;
        ea  = (((int'(ma) << 3) | (int'(ra) << 7) | int'(col)) + 'h400) & 'hffff;
        bgb = memf(ea[15:0], 1'b0);
        fgb = memf(ea[15:0] | 16'h8000, 1'b1);
        for (int p = 0; p < 2; p++) begin
            exp_t e;
            int bn, fn;
            bn = (bgb >> (4*p)) & 'hf;
            fn = (fgb >> (4*p)) & 'hf;
            e.due   = cyc + 2 + p;
            e.blank = !en;
            if (!en)         e.idx = 0;
            else if (fn != 0) e.idx = (int'(m_bank) << 5) | 'h10 | fn;
            else             e.idx = (int'(m_bank) << 5) | bn;
            e.x   = m_flip ? ((256 - (2*int'(col) + p)) & 'hff) : (2*int'(col) + p);
            e.y   = m_flip ? ((240 - int'(line)) & 'hff) : int'(line);
            e.tag = tag;
            q.push_back(e);
        end
        #1;
        check(vram_bg_addr == ea[15:0], "R1", "bg address", int'(vram_bg_addr), ea);
        check(vram_fg_addr == (ea[15:0] | 16'h8000), "R2", "fg address",
              int'(vram_fg_addr), ea | 'h8000);
        @(negedge clk);
        slot_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; slot_valid = 1'b0; line_start = 1'b0; flip_in = 1'b0;
        video_en = 1'b1; crtc_ma = '0; crtc_ra = '0; slot_col = '0;
        line_no = '0; bank_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!pix_valid, "R9", "reset pix_valid", int'(pix_valid), 0);

        // R3 R4 R5: mixed layers, various address fields
        new_line(3'd3, 1'b0);
        mode = 0;
        slot(13'h0012, 5'd2,  7'd0,   8'd10, 1'b1, "R3");
        slot(13'h1abc, 5'd31, 7'd127, 8'd10, 1'b1, "R3");
        slot(13'h0fff, 5'd7,  7'd5,   8'd10, 1'b1, "R3");
        repeat (2) @(negedge clk);
        slot(13'h0400, 5'd16, 7'd64,  8'd10, 1'b1, "R3");

        // R4: transparent foreground everywhere
        mode = 1;
        slot(13'h0033, 5'd1, 7'd3,  8'd20, 1'b1, "R4");
        slot(13'h1200, 5'd9, 7'd90, 8'd20, 1'b1, "R4");

        // R5: opaque foreground on both nibbles
        mode = 2;
        slot(13'h0033, 5'd1, 7'd3,  8'd21, 1'b1, "R5");
        slot(13'h0777, 5'd4, 7'd44, 8'd21, 1'b1, "R5");

        // R4 and R5 within one byte: low transparent, high opaque
        mode = 3;
        slot(13'h0101, 5'd3, 7'd11, 8'd22, 1'b1, "R4 R5");
        slot(13'h1f0f, 5'd0, 7'd99, 8'd22, 1'b1, "R4 R5");

        // R6: flip edges
        mode = 0;
        new_line(3'd6, 1'b1);
        slot(13'h0002, 5'd0, 7'd0,   8'd0,   1'b1, "R6");
        slot(13'h0002, 5'd0, 7'd127, 8'd250, 1'b1, "R6");
        slot(13'h0abc, 5'd5, 7'd64,  8'd239, 1'b1, "R6");

        // R7: video disabled with opaque data present
        mode = 2;
        new_line(3'd1, 1'b0);
        slot(13'h0044, 5'd2, 7'd8, 8'd30, 1'b0, "R7");
        slot(13'h0045, 5'd2, 7'd9, 8'd30, 1'b1, "R7");

        // R8: mid-line changes ignored until the next line start
        mode = 0;
        new_line(3'd2, 1'b0);
        @(negedge clk);
        bank_in = 3'd5;
        flip_in = 1'b1;
        slot(13'h0066, 5'd6, 7'd6,  8'd40, 1'b1, "R8");
        slot(13'h0067, 5'd6, 7'd70, 8'd40, 1'b1, "R8");
        new_line(3'd5, 1'b1);
        slot(13'h0068, 5'd6, 7'd6,  8'd41, 1'b1, "R8");

        repeat (6) @(negedge clk);
        check(q.size() == 0, "R3", "pixels outstanding", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule